// File: doc/BRIEF.md
# Maskable Secondary Address Matcher

This block sits beside the bit-level engine of an I2C target and answers one question: should the 7-bit address just received be acknowledged through the second own-address slot? Software configures the block through one 32-bit control word on a simple register port. The word holds an enable flag, a 3-bit mask code and the 7-bit address to compare against.

The mask code sets how many low address bits are don't-care. Code 0 demands an exact match and code 7 accepts any address. When the code is nonzero, the two reserved address groups (upper four bits all zero or all one) are refused even if the masked compare succeeds.

While matching is enabled, the address and mask fields are frozen against writes, but the enable flag can still be written. A register update takes a configurable number of cycles to settle. A second write that arrives during that window is held off by lowering the ready signal. The decision is registered and appears one clock after the address strobe.

Top module: `sec_addr_match`

## Requirements
- R1: After a synchronous reset, the control word reads as 0x00000000 and `match_o` is 0.
- R2: Control word layout: bit 15 is the enable, bits 10:8 are the mask code, and bits 7:1 are the address, with `rx_addr[6:0]` lining up with address bits 7:1. All other bits read 0 and ignore writes, so writing 0xFFFFFFFF while disabled reads back 0x000087FE.
- R3: While the enable bit is 0, every strobed address yields `match_o` = 0.
- R4: With mask code n (0..7) and the enable bit set, an address that is not refused under R6 matches exactly when bits [7:n+1] of the received address equal the same bits of the stored address.
- R5: Mask code 7 performs no comparison, so every non-reserved address matches when enabled.
- R6: With a nonzero mask code, a received address whose upper four bits are 0000 or 1111 never matches.
- R7: With mask code 0, a reserved address that equals the stored address exactly does match when enabled.
- R8: A write accepted while the enable bit is 1 leaves the address and mask fields unchanged but still updates the enable bit.
- R9: The lock is judged from the enable value held before the write, so a single write that sets enable=1 together with new address and mask values takes effect in full.
- R10: After a write is accepted, a further write is stalled (`reg_ready` = 0) for exactly WR_LAT cycles.
- R11: Reads complete with `reg_ready` = 1 at all times, including inside a pending write window, and a write issued when no write is pending completes with no wait.
- R12: `match_o` updates on the clock edge that samples `rx_stb` = 1 and holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (control word) |
| reg_ready | output | 1 | Access completes on this cycle's clock edge |
| rx_stb | input | 1 | Received address valid |
| rx_addr | input | 7 | Received address bits 7:1 |
| match_o | output | 1 | Registered acknowledge decision |

## Verification
The bench builds the block with WR_LAT = 3. With that setting, the stall count of a back-to-back write is small enough to count exactly, and a read issued inside the pending window shows that reads are never held. With the 7-bit address space, the bench can sweep all 128 received addresses against every mask code for four stored addresses, two of them reserved. The sweep covers every masked-compare boundary and both the reserved refusal and the mask-0 exception.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int CW_W    = 32;  // control word width
  localparam int ADR_W   = 7;   // address bits 7:1
  localparam int MSK_W   = 3;   // mask code width
  localparam int EN_POS  = 15;  // enable bit position
  localparam int MSK_LO  = 8;   // mask code lsb
  localparam int ADR_LO  = 1;   // address lsb
  localparam int RSV_W   = 4;   // upper bits that mark reserved addresses

  typedef struct packed {
    logic             en;
    logic [MSK_W-1:0] msk;
    logic [ADR_W-1:0] adr;
  } sam_cfg_t;
endpackage

// File: rtl/sam_wr_gate.sv
module sam_wr_gate #(
  parameter int WR_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_sel,
  input  logic bus_wr,
  output logic bus_ready,
  output logic wr_fire
);
  localparam int CNT_W = (WR_LAT < 1) ? 1 : $clog2(WR_LAT + 1);

  generate
    if (WR_LAT == 0) begin : g_nolat
      assign bus_ready = 1'b1;
      assign wr_fire   = bus_sel & bus_wr;
    end else begin : g_lat
      logic [CNT_W-1:0] pend_q;
      logic             busy;
      assign busy      = (pend_q != '0);
      assign bus_ready = ~(bus_sel & bus_wr & busy);
      assign wr_fire   = bus_sel & bus_wr & ~busy;

      always_ff @(posedge clk) begin
        if (rst)
          pend_q <= '0;
        else if (wr_fire)
          pend_q <= CNT_W'(WR_LAT);
        else if (busy)
          pend_q <= pend_q - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sam_regfile.sv
module sam_regfile
  import sam_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_fire,
  input  logic [CW_W-1:0] wdata,
  output sam_cfg_t        cfg
);
  sam_cfg_t cfg_q;
  assign cfg = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_fire) begin
      cfg_q.en <= wdata[EN_POS];
      // fields frozen while the previously held enable is set
      if (!cfg_q.en) begin
        cfg_q.msk <= wdata[MSK_LO +: MSK_W];
        cfg_q.adr <= wdata[ADR_LO +: ADR_W];
      end
    end
  end
endmodule

// File: rtl/sam_matcher.sv
module sam_matcher
  import sam_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [ADR_W-1:0] rx,
  input  sam_cfg_t         cfg,
  output logic             hit_q
);
  logic [ADR_W-1:0] miss;
  logic             eq, rsv, hit_d;

  // index i holds address bit i+1; mask code n ignores indices below n
  generate
    for (genvar i = 0; i < ADR_W; i++) begin : g_bit
      logic care;
      assign care    = (MSK_W'(i) >= cfg.msk) || (i >= (1 << MSK_W));
      assign miss[i] = care & (rx[i] ^ cfg.adr[i]);
    end
  endgenerate

  assign eq    = (miss == '0);
  assign rsv   = (rx[ADR_W-1 -: RSV_W] == '0) || (rx[ADR_W-1 -: RSV_W] == '1);
  assign hit_d = cfg.en & eq & ~((cfg.msk != '0) & rsv);

  always_ff @(posedge clk) begin
    if (rst)
      hit_q <= 1'b0;
    else if (stb)
      hit_q <= hit_d;
  end
endmodule

// File: rtl/sec_addr_match.sv
module sec_addr_match
  import sam_pkg::*;
#(
  parameter int WR_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [CW_W-1:0]  reg_wdata,
  output logic [CW_W-1:0]  reg_rdata,
  output logic             reg_ready,
  input  logic             rx_stb,
  input  logic [ADR_W-1:0] rx_addr,
  output logic             match_o
);
  sam_cfg_t cfg;
  logic     wr_fire;

  sam_wr_gate #(.WR_LAT(WR_LAT)) u_gate (
    .clk(clk), .rst(rst), .bus_sel(reg_sel), .bus_wr(reg_wr),
    .bus_ready(reg_ready), .wr_fire(wr_fire)
  );

  sam_regfile u_regs (
    .clk(clk), .rst(rst), .wr_fire(wr_fire), .wdata(reg_wdata), .cfg(cfg)
  );

  sam_matcher u_match (
    .clk(clk), .rst(rst), .stb(rx_stb), .rx(rx_addr), .cfg(cfg), .hit_q(match_o)
  );

  always_comb begin
    reg_rdata                      = '0;
    reg_rdata[EN_POS]              = cfg.en;
    reg_rdata[MSK_LO +: MSK_W]     = cfg.msk;
    reg_rdata[ADR_LO +: ADR_W]     = cfg.adr;
  end
endmodule

// File: rtl/sam_checks.sv
module sam_checks
  import sam_pkg::*;
#(
  parameter int WR_LAT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [CW_W-1:0]  reg_rdata,
  input logic             reg_ready,
  input logic             rx_stb,
  input logic [ADR_W-1:0] rx_addr,
  input logic             match_o
);
  localparam logic [CW_W-1:0] LIVE = (CW_W'(1) << EN_POS)
                                   | (CW_W'((1 << MSK_W) - 1) << MSK_LO)
                                   | (CW_W'((1 << ADR_W) - 1) << ADR_LO);
  logic acc_wr, rsv_in;
  assign acc_wr = reg_sel & reg_wr & reg_ready;
  assign rsv_in = (rx_addr[ADR_W-1 -: RSV_W] == '0) || (rx_addr[ADR_W-1 -: RSV_W] == '1);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && !match_o));

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~LIVE) == '0);

  a_r3_disabled_nack: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && !reg_rdata[EN_POS]) |=> !match_o);

  a_r6_reserved_nack: assert property (@(posedge clk) disable iff (rst)
    (rx_stb && reg_rdata[MSK_LO +: MSK_W] != '0 && rsv_in) |=> !match_o);

  a_r8_fields_locked: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && reg_rdata[EN_POS]) |=>
      (reg_rdata[EN_POS-1:0] == $past(reg_rdata[EN_POS-1:0])));

  a_r11_read_nowait: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && !reg_wr) |-> reg_ready);

  a_r12_match_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_stb |=> $stable(match_o));

  generate
    if (WR_LAT > 0) begin : g_stall
      a_r10_back_to_back_stall: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> !(reg_sel && reg_wr && reg_ready));
    end
  endgenerate
endmodule

bind sec_addr_match sam_checks #(.WR_LAT(WR_LAT)) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .reg_ready(reg_ready), .rx_stb(rx_stb),
  .rx_addr(rx_addr), .match_o(match_o)
);

// File: tb/sec_addr_match_tb.sv
`timescale 1ns/100ps
module sec_addr_match_tb_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ready;
  logic        rx_stb = 1'b0;
  logic [6:0]  rx_addr = '0;
  logic        match_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sec_addr_match #(.WR_LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .rx_stb(rx_stb), .rx_addr(rx_addr), .match_o(match_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_write(input logic [31:0] d, output int stalls);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_wdata = d; stalls = 0;
    #1;
    while (!reg_ready) begin
      @(negedge clk); #1; stalls++;
    end
    @(posedge clk);
  endtask

  task automatic do_idle();
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic do_read(output logic [31:0] d, output logic rdy);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0;
    #1; d = reg_rdata; rdy = reg_ready;
    @(posedge clk);
  endtask

  task automatic strobe(input logic [6:0] a, output logic m);
    @(negedge clk);
    rx_addr = a; rx_stb = 1;
    @(negedge clk);
    rx_stb = 0;
    #1; m = match_o;
  endtask

  function automatic logic expect_hit(input bit en, input int n, input int own, input int rx);
    bit eq, rsv;
    eq  = ((rx ^ own) >> n) == 0;
    rsv = ((rx >> 3) == 0) || ((rx >> 3) == 15);
    return en && eq && !(n != 0 && rsv);
  endfunction

  function automatic logic [31:0] cword(input bit en, input int n, input int a);
    return (32'(en) << 15) | (32'(n) << 8) | (32'(a) << 1);
  endfunction

  initial begin
    #(5ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] rd;
    logic rdy, m;
    int st;
    int owns[4] = '{7'h03, 7'h55, 7'h2A, 7'h7C};

    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1 reset state
    do_read(rd, rdy); do_idle();
    chk("R1 rdata", rd, 32'h0);
    chk("R1 match", {31'b0, match_o}, 32'h0);

    // R2 unused bits, R11 first write has no wait
    do_write(32'hFFFF_FFFF, st);
    chk("R11 write no wait", st, 0);
    // R11 read inside pending window
    do_read(rd, rdy); do_idle();
    chk("R11 read ready", {31'b0, rdy}, 32'h1);
    chk("R2 layout", rd, 32'h0000_87FE);

    // R10 back-to-back stall
    do_write(32'h0, st);
    do_write(cword(0, 2, 7'h11), st);
    do_idle();
    chk("R10 stall cycles", st, LAT);
    // R8: enabled write leaves fields; enable still written
    do_write(cword(1, 2, 7'h11), st); do_idle();
    repeat (LAT) @(negedge clk);
    do_write(cword(1, 5, 7'h40), st); do_idle();
    do_read(rd, rdy); do_idle();
    chk("R8 fields locked", rd, cword(1, 2, 7'h11));
    repeat (LAT) @(negedge clk);
    do_write(cword(0, 6, 7'h22), st); do_idle();
    do_read(rd, rdy); do_idle();
    chk("R8 enable cleared, fields kept", rd, cword(0, 2, 7'h11));

    // R3 disabled sweep
    for (int rx = 0; rx < 128; rx++) begin
      strobe(7'(rx), m);
      chk("R3 disabled", {31'b0, m}, 32'h0);
    end

    // R4..R7 and R9 exhaustive sweep
    for (int ai = 0; ai < 4; ai++) begin
      for (int n = 0; n < 8; n++) begin
        do_write(32'h0, st);
        do_write(cword(1, n, owns[ai]), st);
        do_idle();
        do_read(rd, rdy); do_idle();
        chk("R9 enable with fields", rd, cword(1, n, owns[ai]));
        for (int rx = 0; rx < 128; rx++) begin
          bit rsv;
          string tag;
          rsv = ((rx >> 3) == 0) || ((rx >> 3) == 15);
          if (n == 7) tag = "R5 mask7";
          else if (rsv && n != 0) tag = "R6 reserved";
          else if (rsv) tag = "R7 mask0 reserved";
          else tag = "R4 masked compare";
          strobe(7'(rx), m);
          chk(tag, {31'b0, m}, {31'b0, expect_hit(1, n, owns[ai], rx)});
        end
      end
    end

    // R12 timing and hold: config is enabled, mask 7, addr 0x7C
    strobe(7'h40, m);
    chk("R12 hit", {31'b0, m}, 32'h1);
    @(negedge clk); rx_addr = 7'h00;
    repeat (5) @(negedge clk);
    #1; chk("R12 hold", {31'b0, match_o}, 32'h1);
    @(negedge clk); rx_addr = 7'h05; rx_stb = 1;
    #1; chk("R12 before edge", {31'b0, match_o}, 32'h1);
    @(negedge clk); rx_stb = 0;
    #1; chk("R12 after edge", {31'b0, match_o}, 32'h0);

    report();
  end
endmodule